// File: doc/BRIEF.md
# Effective-Privilege Memory Protection Checker

This block decides whether one memory access may proceed under physical memory protection. The requester supplies the hart's current privilege, the two machine-status fields that choose the privilege for data accesses (the modify-privilege flag and the previous-privilege field), a small set of protection entries (one configuration byte and one word-address register each), and the access itself: its byte address and whether it is an instruction fetch, a load or a store. The answer is combinational. It is either a permit or a fault, and a fault comes with the exception cause code.

Loads and stores are checked at the privilege held in the previous-privilege field whenever the modify-privilege flag is set. Instruction fetches are always checked at the real privilege. As a result, a fetch can pass while the load or store it fetches is refused. The block also owns the previous-privilege field. Software writes it, and a trap overwrites it on the clock edge where the trap is taken. A 32-bit status image shows the field and the flag at their architectural bit positions.

Top module: `pmp_access_guard`

## Requirements
- R1: `mstatus_view` has `mprv` at bit 17 and the previous-privilege field `mpp` at bits 12:11. All other bits are zero, so `mprv`=1 with `mpp`=3 reads 0x00021800. After reset `mpp` is 0 (user).
- R2: Loads (`req_kind`=1) and stores (`req_kind` 2 or 3) are checked at privilege `mpp` when `mprv`=1, and at `cur_priv` when `mprv`=0. Privilege code 3 is machine and any other code is user.
- R3: An instruction fetch (`req_kind`=0) is always checked at `cur_priv`, whatever the values of `mprv` and `mpp`.
- R4: At machine privilege, an access is permitted if it matches no entry, or if the first entry it matches has its lock bit clear.
- R5: At user privilege, an access that matches no entry faults, whatever its kind.
- R6: A fault sets `req_fault` and gives `fault_cause` 1 for a fetch, 5 for a load and 7 for a store. When there is no fault, or when `req_valid`=0, `req_fault`, `req_permit` and `fault_cause` are all 0.
- R7: Configuration byte i sits at `pmp_cfg[8i+7:8i]`. Bit 0 is read, bit 1 is write, bit 2 is execute, bits 4:3 are the match mode and bit 7 is the lock. The first matching entry grants a load by its read bit, a store by its write bit and a fetch by its execute bit.
- R8: Match mode 1 (range) matches word addresses in the interval [entry i-1 address, entry i address). Entry 0 uses a lower bound of 0. The word address is `req_addr[31:2]`, and entry i's register is `pmp_addr[30i+29:30i]`.
- R9: Match mode 3 (aligned power of two) matches the block whose size is given by the trailing ones of the entry address: t trailing ones cover 2^(t+1) words. Match mode 2 matches exactly one word. Mode 0 never matches.
- R10: When several entries match, the lowest-numbered one decides the outcome.
- R11: A matching entry with its lock bit set enforces its read, write and execute bits at machine privilege as well.
- R12: On a clock edge with `trap_take`=1, `mpp` becomes 3 if `cur_priv` is 3 and 0 otherwise. This takes priority over a software write in the same cycle.
- R13: On a clock edge with `mpp_wr_en`=1 and no trap, `mpp` takes 3 if `mpp_wr_data` is 3 and 0 for any other value. Without a trap or a write, `mpp` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_priv | input | 2 | Current hart privilege (3 machine, 0 user) |
| mprv | input | 1 | Modify-privilege flag for data accesses |
| mpp_wr_en | input | 1 | Software write strobe for the previous-privilege field |
| mpp_wr_data | input | 2 | Value for a software write |
| trap_take | input | 1 | A trap is taken on this clock edge |
| pmp_cfg | input | 8*N_ENTRIES | Packed configuration bytes, entry 0 lowest |
| pmp_addr | input | (XLEN-2)*N_ENTRIES | Packed word-address registers, entry 0 lowest |
| req_valid | input | 1 | Access request present |
| req_kind | input | 2 | 0 fetch, 1 load, 2 or 3 store |
| req_addr | input | XLEN | Byte address of the access |
| req_permit | output | 1 | Access allowed |
| req_fault | output | 1 | Access refused |
| fault_cause | output | 4 | Exception cause for a refused access |
| mpp | output | 2 | Previous-privilege field |
| mstatus_view | output | XLEN | Status image holding `mprv` and `mpp` |

## Verification
The permit, fault and cause outputs depend only on the current inputs, so each of them is due in the same cycle as its stimulus. The bench drives a request, waits 1 ns and samples well clear of any clock edge. The previous-privilege field and the status image change on the first rising edge after a trap or write strobe is raised on a falling edge. The bench therefore samples them on the following falling edge, once the strobe has been lowered. Each scenario reprograms the entries only between samples, so every check sees one stable configuration.

// File: rtl/pmp_guard_pkg.sv
package pmp_guard_pkg;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam logic [1:0] AMODE_OFF   = 2'd0;
  localparam logic [1:0] AMODE_TOR   = 2'd1;
  localparam logic [1:0] AMODE_NA4   = 2'd2;
  localparam logic [1:0] AMODE_NAPOT = 2'd3;

  localparam logic [3:0] CAUSE_FETCH = 4'd1;
  localparam logic [3:0] CAUSE_LOAD  = 4'd5;
  localparam logic [3:0] CAUSE_STORE = 4'd7;

  localparam int unsigned STAT_MPRV_BIT = 17;
  localparam int unsigned STAT_MPP_LO   = 11;

  typedef struct packed {
    logic       lock;
    logic [1:0] rsvd;
    logic [1:0] amode;
    logic       x;
    logic       w;
    logic       r;
  } prot_cfg_t;

endpackage

// File: rtl/pmp_eff_priv.sv
module pmp_eff_priv
  import pmp_guard_pkg::*;
(
  input  logic [1:0] cur_priv,
  input  logic       mprv,
  input  logic [1:0] mpp,
  input  logic [1:0] req_kind,
  output logic       eff_is_m
);

  logic is_fetch;

  always_comb begin
    is_fetch = (req_kind == 2'd0);
    if (!is_fetch && mprv) begin
      eff_is_m = (mpp == PRIV_M);
    end else begin
      eff_is_m = (cur_priv == PRIV_M);
    end
  end

endmodule

// File: rtl/pmp_entry_match.sv
module pmp_entry_match
  import pmp_guard_pkg::*;
#(
  parameter int unsigned WORD_W = 30
) (
  input  logic [1:0]        amode,
  input  logic [WORD_W-1:0] lo_bound,
  input  logic [WORD_W-1:0] entry_addr,
  input  logic [WORD_W-1:0] waddr,
  output logic              hit
);

  logic [WORD_W-1:0] napot_span;

  always_comb begin
    napot_span = entry_addr ^ (entry_addr + WORD_W'(1));
    unique case (amode)
      AMODE_TOR:   hit = (waddr >= lo_bound) && (waddr < entry_addr);
      AMODE_NA4:   hit = (waddr == entry_addr);
      AMODE_NAPOT: hit = ((waddr ^ entry_addr) & ~napot_span) == '0;
      default:     hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/pmp_perm_resolve.sv
module pmp_perm_resolve
  import pmp_guard_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_ENTRIES-1:0]   hit,
  input  logic [8*N_ENTRIES-1:0] cfg_bus,
  input  logic                   req_valid,
  input  logic [1:0]             req_kind,
  input  logic                   eff_is_m,
  output logic                   req_permit,
  output logic                   req_fault,
  output logic [3:0]             fault_cause
);

  logic      sel_found;
  prot_cfg_t sel_cfg;
  logic      kind_ok;
  logic      allowed;
  logic      unused_cfg;

  always_comb begin
    sel_found = 1'b0;
    sel_cfg   = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (hit[i]) begin
        sel_found = 1'b1;
        sel_cfg   = prot_cfg_t'(cfg_bus[8*i +: 8]);
      end
    end
  end

  always_comb begin
    if (req_kind[1]) begin
      kind_ok = sel_cfg.w;
    end else if (req_kind[0]) begin
      kind_ok = sel_cfg.r;
    end else begin
      kind_ok = sel_cfg.x;
    end

    if (!sel_found) begin
      allowed = eff_is_m;
    end else if (eff_is_m && !sel_cfg.lock) begin
      allowed = 1'b1;
    end else begin
      allowed = kind_ok;
    end

    req_permit  = req_valid && allowed;
    req_fault   = req_valid && !allowed;
    fault_cause = 4'd0;
    if (req_fault) begin
      if (req_kind[1]) begin
        fault_cause = CAUSE_STORE;
      end else if (req_kind[0]) begin
        fault_cause = CAUSE_LOAD;
      end else begin
        fault_cause = CAUSE_FETCH;
      end
    end
  end

  assign unused_cfg = ^{sel_cfg.rsvd, sel_cfg.amode};

  // R5: user privilege with no matching entry never proceeds
  a_r5_user_nomatch_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !eff_is_m && (hit == '0)) |-> req_fault);

  // R4: machine privilege with no matching entry always proceeds
  a_r4_machine_nomatch_permits: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && eff_is_m && (hit == '0)) |-> req_permit);

  // R6: no request, no answer
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!req_permit && !req_fault && fault_cause == 4'd0));

endmodule

// File: rtl/pmp_mpp_reg.sv
module pmp_mpp_reg
  import pmp_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trap_take,
  input  logic [1:0] cur_priv,
  input  logic       wr_en,
  input  logic [1:0] wr_data,
  output logic [1:0] mpp
);

  logic [1:0] mpp_q;
  logic [1:0] mpp_nxt;
  logic       mpp_en;

  always_comb begin
    mpp_en  = 1'b0;
    mpp_nxt = mpp_q;
    if (trap_take) begin
      mpp_en  = 1'b1;
      mpp_nxt = (cur_priv == PRIV_M) ? PRIV_M : PRIV_U;
    end else if (wr_en) begin
      mpp_en  = 1'b1;
      mpp_nxt = (wr_data == PRIV_M) ? PRIV_M : PRIV_U;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mpp_q <= PRIV_U;
    end else if (mpp_en) begin
      mpp_q <= mpp_nxt;
    end
  end

  assign mpp = mpp_q;

  // R12: trap from machine mode leaves the field at machine
  a_r12_trap_from_m: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_take && cur_priv == PRIV_M) |=> (mpp == PRIV_M));

  // R12: trap from user mode leaves the field at user
  a_r12_trap_from_u: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_take && cur_priv != PRIV_M) |=> (mpp == PRIV_U));

  // R13: only the two supported privileges are ever held
  a_r13_mpp_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (mpp == PRIV_M) || (mpp == PRIV_U));

  // R13: the field is stable without a trap or a write
  a_r13_mpp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_take && !wr_en) |=> $stable(mpp));

endmodule

// File: rtl/pmp_access_guard.sv
module pmp_access_guard
  import pmp_guard_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 4,
  parameter int unsigned XLEN      = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [1:0]                    cur_priv,
  input  logic                          mprv,
  input  logic                          mpp_wr_en,
  input  logic [1:0]                    mpp_wr_data,
  input  logic                          trap_take,
  input  logic [8*N_ENTRIES-1:0]        pmp_cfg,
  input  logic [(XLEN-2)*N_ENTRIES-1:0] pmp_addr,
  input  logic                          req_valid,
  input  logic [1:0]                    req_kind,
  input  logic [XLEN-1:0]               req_addr,
  output logic                          req_permit,
  output logic                          req_fault,
  output logic [3:0]                    fault_cause,
  output logic [1:0]                    mpp,
  output logic [XLEN-1:0]               mstatus_view
);

  localparam int unsigned WORD_W = XLEN - 2;

  logic [WORD_W-1:0]    waddr;
  logic [N_ENTRIES-1:0] hit;
  logic [N_ENTRIES-1:0] lock_bits;
  logic                 eff_is_m;
  logic [1:0]           unused_byte_off;

  assign waddr           = req_addr[XLEN-1:2];
  assign unused_byte_off = req_addr[1:0];

  pmp_mpp_reg i_mpp_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .trap_take (trap_take),
    .cur_priv  (cur_priv),
    .wr_en     (mpp_wr_en),
    .wr_data   (mpp_wr_data),
    .mpp       (mpp)
  );

  pmp_eff_priv i_eff_priv (
    .cur_priv (cur_priv),
    .mprv     (mprv),
    .mpp      (mpp),
    .req_kind (req_kind),
    .eff_is_m (eff_is_m)
  );

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
    logic [WORD_W-1:0] lo_bound;
    prot_cfg_t         ecfg;

    assign ecfg         = prot_cfg_t'(pmp_cfg[8*g +: 8]);
    assign lock_bits[g] = ecfg.lock;

    if (g == 0) begin : g_first
      assign lo_bound = '0;
    end else begin : g_rest
      assign lo_bound = pmp_addr[WORD_W*(g-1) +: WORD_W];
    end

    pmp_entry_match #(.WORD_W(WORD_W)) i_match (
      .amode      (ecfg.amode),
      .lo_bound   (lo_bound),
      .entry_addr (pmp_addr[WORD_W*g +: WORD_W]),
      .waddr      (waddr),
      .hit        (hit[g])
    );
  end

  pmp_perm_resolve #(.N_ENTRIES(N_ENTRIES)) i_resolve (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit         (hit),
    .cfg_bus     (pmp_cfg),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .eff_is_m    (eff_is_m),
    .req_permit  (req_permit),
    .req_fault   (req_fault),
    .fault_cause (fault_cause)
  );

  always_comb begin
    mstatus_view                                   = '0;
    mstatus_view[STAT_MPRV_BIT]                    = mprv;
    mstatus_view[STAT_MPP_LO+1:STAT_MPP_LO]        = mpp;
  end

  // R3: a machine-mode fetch with no locked entry proceeds regardless of mprv/mpp
  a_r3_fetch_real_priv: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd0 && cur_priv == PRIV_M && lock_bits == '0)
      |-> req_permit);

  // R2: with mprv set and a user-level previous privilege, unmatched data access faults
  a_r2_data_uses_mpp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind != 2'd0 && mprv && mpp == PRIV_U && hit == '0)
      |-> req_fault);

  // R6: the cause code follows the access kind
  a_r6_cause_by_kind: assert property (@(posedge clk) disable iff (!rst_n)
    req_fault |-> (fault_cause == (req_kind[1] ? CAUSE_STORE :
                                   req_kind[0] ? CAUSE_LOAD : CAUSE_FETCH)));

  // R4: machine privilege on data with an unlocked table always proceeds
  a_r4_unlocked_machine_data: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind != 2'd0 && mprv && mpp == PRIV_M && lock_bits == '0)
      |-> req_permit);

endmodule

// File: tb/test_pmp_access_guard.sv
`timescale 1ns/1ps
module test_pmp_access_guard;

  localparam int N  = 4;
  localparam int XL = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    cur_priv;
  logic          mprv;
  logic          mpp_wr_en;
  logic [1:0]    mpp_wr_data;
  logic          trap_take;
  logic [8*N-1:0]  pmp_cfg;
  logic [30*N-1:0] pmp_addr;
  logic          req_valid;
  logic [1:0]    req_kind;
  logic [XL-1:0] req_addr;
  logic          req_permit;
  logic          req_fault;
  logic [3:0]    fault_cause;
  logic [1:0]    mpp;
  logic [XL-1:0] mstatus_view;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  pmp_access_guard #(.N_ENTRIES(N), .XLEN(XL)) i_pmp_access_guard (
    .clk (clk), .rst_n (rst_n), .cur_priv (cur_priv), .mprv (mprv),
    .mpp_wr_en (mpp_wr_en), .mpp_wr_data (mpp_wr_data), .trap_take (trap_take),
    .pmp_cfg (pmp_cfg), .pmp_addr (pmp_addr), .req_valid (req_valid),
    .req_kind (req_kind), .req_addr (req_addr), .req_permit (req_permit),
    .req_fault (req_fault), .fault_cause (fault_cause), .mpp (mpp),
    .mstatus_view (mstatus_view)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_entry(int idx, logic [7:0] c, logic [29:0] a);
    pmp_cfg[8*idx +: 8]   = c;
    pmp_addr[30*idx +: 30] = a;
  endtask

  task automatic clear_entries();
    pmp_cfg  = '0;
    pmp_addr = '0;
  endtask

  // kind: 0 fetch, 1 load, 2 store; exp_cause 0 means permitted
  task automatic access(string req, logic [1:0] kind, logic [31:0] addr, logic [3:0] exp_cause);
    req_valid = 1'b1;
    req_kind  = kind;
    req_addr  = addr;
    #1;
    chk(req, "permit", 32'(req_permit), 32'(exp_cause == 4'd0));
    chk(req, "fault",  32'(req_fault),  32'(exp_cause != 4'd0));
    chk(req, "cause",  32'(fault_cause), 32'(exp_cause));
    req_valid = 1'b0;
  endtask

  task automatic write_mpp(logic [1:0] v, logic with_trap);
    @(negedge clk);
    mpp_wr_en   = 1'b1;
    mpp_wr_data = v;
    trap_take   = with_trap;
    @(negedge clk);
    mpp_wr_en   = 1'b0;
    trap_take   = 1'b0;
  endtask

  task automatic take_trap();
    @(negedge clk);
    trap_take = 1'b1;
    @(negedge clk);
    trap_take = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "mpp after reset", 32'(mpp), 32'h0);
    chk("R1", "status after reset", mstatus_view, 32'h0);
    req_valid = 1'b0;
    req_kind  = 2'd1;
    #1;
    chk("R6", "idle fault", 32'(req_fault), 32'h0);
    chk("R6", "idle permit", 32'(req_permit), 32'h0);
    chk("R6", "idle cause", 32'(fault_cause), 32'h0);
  endtask

  task automatic t_mprv_switch();
    clear_entries();
    cur_priv = 2'd3;
    mprv     = 1'b1;
    write_mpp(2'd3, 1'b0);
    chk("R1", "status mprv+mpp=M", mstatus_view, 32'h0002_1800);
    access("R4", 2'd1, 32'h0000_1000, 4'd0);
    access("R4", 2'd2, 32'h0000_1000, 4'd0);
    write_mpp(2'd0, 1'b0);
    chk("R13", "mpp write U", 32'(mpp), 32'h0);
    access("R2", 2'd1, 32'h0000_1000, 4'd5);
    access("R2", 2'd2, 32'h0000_1000, 4'd7);
    access("R3", 2'd0, 32'h0000_1000, 4'd0);
    take_trap();
    chk("R12", "mpp after trap from M", 32'(mpp), 32'h3);
    chk("R1", "status after trap", mstatus_view, 32'h0002_1800);
    access("R2", 2'd1, 32'h0000_1000, 4'd0);
    write_mpp(2'd0, 1'b0);
    mprv = 1'b0;
    access("R2", 2'd1, 32'h0000_1000, 4'd0);
    chk("R1", "status mprv=0", mstatus_view, 32'h0);
  endtask

  task automatic t_user_nomatch();
    clear_entries();
    cur_priv = 2'd0;
    mprv     = 1'b0;
    access("R5", 2'd0, 32'h0000_0100, 4'd1);
    access("R5", 2'd1, 32'h8000_0000, 4'd5);
    access("R5", 2'd3, 32'hFFFF_FFFC, 4'd7);
    mprv = 1'b1;
    write_mpp(2'd3, 1'b0);
    access("R3", 2'd0, 32'h0000_0100, 4'd1);
    access("R2", 2'd1, 32'h0000_0100, 4'd0);
    mprv = 1'b0;
    write_mpp(2'd0, 1'b0);
  endtask

  task automatic t_regions();
    clear_entries();
    cur_priv = 2'd0;
    mprv     = 1'b0;
    set_entry(0, 8'h09, 30'h400);
    set_entry(1, 8'h0B, 30'h800);
    set_entry(2, 8'h1C, 30'h101F);
    set_entry(3, 8'h11, 30'h1400);
    access("R8", 2'd1, 32'h0000_0FFC, 4'd0);
    access("R7", 2'd2, 32'h0000_0000, 4'd7);
    access("R8", 2'd1, 32'h0000_1000, 4'd0);
    access("R7", 2'd2, 32'h0000_1800, 4'd0);
    access("R8", 2'd2, 32'h0000_2000, 4'd7);
    access("R9", 2'd0, 32'h0000_40FC, 4'd0);
    access("R9", 2'd0, 32'h0000_4100, 4'd1);
    access("R9", 2'd0, 32'h0000_3FFC, 4'd1);
    access("R7", 2'd1, 32'h0000_4000, 4'd5);
    access("R9", 2'd1, 32'h0000_5000, 4'd0);
    access("R9", 2'd1, 32'h0000_5004, 4'd5);
    set_entry(3, 8'h01, 30'h1400);
    access("R9", 2'd1, 32'h0000_5000, 4'd5);
    cur_priv = 2'd3;
    access("R4", 2'd2, 32'h0000_4000, 4'd0);
  endtask

  task automatic t_priority_lock();
    clear_entries();
    cur_priv = 2'd0;
    mprv     = 1'b0;
    set_entry(0, 8'h10, 30'h1800);
    set_entry(1, 8'h1B, 30'h181F);
    access("R10", 2'd1, 32'h0000_6000, 4'd5);
    access("R10", 2'd1, 32'h0000_6004, 4'd0);
    access("R10", 2'd2, 32'h0000_60FC, 4'd0);
    cur_priv = 2'd3;
    access("R4", 2'd1, 32'h0000_6000, 4'd0);
    set_entry(0, 8'h90, 30'h1800);
    access("R11", 2'd1, 32'h0000_6000, 4'd5);
    access("R11", 2'd0, 32'h0000_6000, 4'd1);
    access("R11", 2'd1, 32'h0000_6004, 4'd0);
  endtask

  task automatic t_mpp_field();
    write_mpp(2'd2, 1'b0);
    chk("R13", "write 2 stores U", 32'(mpp), 32'h0);
    write_mpp(2'd3, 1'b0);
    chk("R13", "write 3 stores M", 32'(mpp), 32'h3);
    repeat (3) @(negedge clk);
    chk("R13", "hold", 32'(mpp), 32'h3);
    cur_priv = 2'd0;
    take_trap();
    chk("R12", "trap from U", 32'(mpp), 32'h0);
    cur_priv = 2'd3;
    write_mpp(2'd0, 1'b1);
    chk("R12", "trap beats write", 32'(mpp), 32'h3);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    rst_n       = 1'b0;
    cur_priv    = 2'd3;
    mprv        = 1'b0;
    mpp_wr_en   = 1'b0;
    mpp_wr_data = 2'd0;
    trap_take   = 1'b0;
    pmp_cfg     = '0;
    pmp_addr    = '0;
    req_valid   = 1'b0;
    req_kind    = 2'd0;
    req_addr    = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mprv_switch();
    t_user_nomatch();
    t_regions();
    t_priority_lock();
    t_mpp_field();
    done = 1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

endmodule